// File: doc/BRIEF.md
# Four-Word Flop Queue with Consistency Flag

This block is a shallow first-in-first-out queue of 64-bit words, built entirely from flip-flops. A producer presents a word together with a valid strobe. The word is stored on the next clock edge unless the queue is already full, in which case the word is dropped. The oldest stored word is always visible on the data output, so no read strobe is needed. A consumer removes that word by raising the pop input. When nothing is stored, the data output is forced to zero.

Every output is taken straight from a register: the data word, the full flag, the empty flag and the error flag. As a result, no output moves between clock edges, whatever the inputs do in the meantime. The error flag watches the occupancy counter and the read and write pointers. It rises if their combination is one that legal operation can never produce. Reset is synchronous and active high, and it returns the queue to the empty state.

Top module: `word_queue`

## Requirements
- R1: After a clock edge with `rst` high, `empty` is 1, `full` is 0, `err` is 0 and `q_data` is all zeros.
- R2: On an edge where `in_valid` is 1 and `full` is 0, `in_data` is stored. Words leave the queue in the order they arrived.
- R3: On an edge where `in_valid` is 1 and `full` is 1 (and `pop` is 0), the word is discarded. The stored words, their order and `q_data` are unchanged.
- R4: `q_data` shows the oldest stored word without any strobe. A word pushed into an empty queue appears on `q_data` right after the edge that stores it.
- R5: While the queue holds no word, `empty` is 1 and `q_data` is all zeros.
- R6: On an edge where `pop` is 1 and the queue is not empty, the oldest word is removed. On an edge where `pop` is 1 and the queue is empty (and `in_valid` is 0), nothing changes.
- R7: When the queue holds 1 to 3 words and both `in_valid` and `pop` are 1, the head is removed and the new word is appended on the same edge. The occupancy stays the same.
- R8: When the queue is full and both `in_valid` and `pop` are 1, only the pop takes place. When it is empty and both are 1, only the push takes place.
- R9: `full` is 1 exactly when 4 words are stored, and `full` and `empty` are never 1 together.
- R10: `q_data`, `full`, `empty` and `err` change only at a rising clock edge. Input changes between edges do not affect them.
- R11: `err` rises when the occupancy counter exceeds 4, or when the write-minus-read pointer distance (modulo 4) differs from the counter modulo 4. It stays 0 throughout any legal sequence of inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request to store `in_data` |
| in_data | input | 64 | Word to store |
| pop | input | 1 | Request to remove the head word |
| q_data | output | 64 | Oldest stored word, zero when empty |
| full | output | 1 | Four words stored |
| empty | output | 1 | No word stored |
| err | output | 1 | Internal state inconsistent |

## Verification
The queue is driven in several ways. It is filled to capacity and then drained, which exposes ordering and pointer wrap faults. Pushes are made against a full queue and pops against an empty one; these separate correct discarding from silent corruption. Simultaneous push and pop is applied at one, two, three and four stored words, which tells apart the mid-range case, where occupancy must be kept, from the two end cases, where only one action may happen. A separate pattern changes the inputs between clock edges and confirms that the registered outputs hold still until the next edge.

// File: rtl/wq_pkg.sv
package wq_pkg;

    // Result of arbitrating a push/pop request against the current fill
    typedef struct packed {
        logic push;
        logic pop;
    } wq_op_t;

    // Coarse fill class used to derive the registered flags
    typedef enum logic [1:0] {
        OCC_NONE = 2'd0,
        OCC_SOME = 2'd1,
        OCC_ALL  = 2'd2
    } wq_occ_e;

    // A push is honoured only with space left; a pop only with data present.
    function automatic wq_op_t wq_decide(logic want_push, logic want_pop,
                                         logic at_cap, logic at_zero);
        wq_op_t r;
        r.push = want_push && !at_cap;
        r.pop  = want_pop  && !at_zero;
        return r;
    endfunction

    function automatic wq_occ_e wq_classify(int unsigned cnt, int unsigned depth);
        if (cnt == 0)      return OCC_NONE;
        if (cnt >= depth)  return OCC_ALL;
        return OCC_SOME;
    endfunction

    // True for a counter/pointer combination that legal operation never builds
    function automatic logic wq_state_bad(int unsigned cnt, int unsigned gap,
                                          int unsigned depth);
        return (cnt > depth) || (gap != (cnt % depth));
    endfunction

    // Pointer distance modulo depth, written for any depth
    function automatic int unsigned wq_gap(int unsigned wr, int unsigned rd,
                                           int unsigned depth);
        return (wr >= rd) ? (wr - rd) : (wr + depth - rd);
    endfunction

endpackage

// File: rtl/wq_ctrl.sv
module wq_ctrl
    import wq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          want_push,
    input  logic          want_pop,
    output logic          wr_en,
    output logic [PW-1:0] wr_at,
    output logic [PW-1:0] rd_nxt,
    output logic          head_from_in,
    output logic [CW-1:0] cnt_nxt,
    output logic          bad_nxt
);

    logic [PW-1:0] wr_q, rd_q, wr_n, rd_n;
    logic [CW-1:0] cnt_q, cnt_n;
    wq_op_t        op;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        op    = wq_decide(want_push, want_pop,
                          int'(cnt_q) >= DEPTH, cnt_q == '0);
        wr_n  = op.push ? bump(wr_q) : wr_q;
        rd_n  = op.pop  ? bump(rd_q) : rd_q;
        cnt_n = cnt_q + CW'(op.push) - CW'(op.pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_n;
            rd_q  <= rd_n;
            cnt_q <= cnt_n;
        end
    end

    assign wr_en        = op.push;
    assign wr_at        = wr_q;
    assign rd_nxt       = rd_n;
    // The next head is the incoming word when it lands in the slot read next
    assign head_from_in = op.push && (rd_n == wr_q);
    assign cnt_nxt      = cnt_n;
    assign bad_nxt      = wq_state_bad(int'(cnt_n),
                                       wq_gap(int'(wr_n), int'(rd_n), DEPTH),
                                       DEPTH);

endmodule

// File: rtl/wq_store.sv
module wq_store #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 64,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_at,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [PW-1:0]    rd_sel,
    input  logic             from_in,
    output logic [WIDTH-1:0] head_nxt
);

    logic [WIDTH-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (int'(wr_at) == i))
                slot[i] <= wr_word;
        end
    end

    assign head_nxt = from_in ? wr_word : slot[rd_sel];

endmodule

// File: rtl/wq_outreg.sv
module wq_outreg
    import wq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] head_nxt,
    input  logic [CW-1:0]    cnt_nxt,
    input  logic             bad_nxt,
    output logic [WIDTH-1:0] q_data,
    output logic             full,
    output logic             empty,
    output logic             err
);

    wq_occ_e occ;

    assign occ = wq_classify(int'(cnt_nxt), DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_data <= '0;
            full   <= 1'b0;
            empty  <= 1'b1;
            err    <= 1'b0;
        end else begin
            q_data <= (occ == OCC_NONE) ? '0 : head_nxt;
            full   <= (occ == OCC_ALL);
            empty  <= (occ == OCC_NONE);
            err    <= bad_nxt;
        end
    end

endmodule

// File: rtl/word_queue.sv
module word_queue #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    input  logic             pop,
    output logic [WIDTH-1:0] q_data,
    output logic             full,
    output logic             empty,
    output logic             err
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic             wr_en, from_in, bad_nxt;
    logic [PW-1:0]    wr_at, rd_nxt;
    logic [CW-1:0]    cnt_nxt;
    logic [WIDTH-1:0] head_nxt;

    wq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .want_push    (in_valid),
        .want_pop     (pop),
        .wr_en        (wr_en),
        .wr_at        (wr_at),
        .rd_nxt       (rd_nxt),
        .head_from_in (from_in),
        .cnt_nxt      (cnt_nxt),
        .bad_nxt      (bad_nxt)
    );

    wq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_at    (wr_at),
        .wr_word  (in_data),
        .rd_sel   (rd_nxt),
        .from_in  (from_in),
        .head_nxt (head_nxt)
    );

    wq_outreg #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_out (
        .clk      (clk),
        .rst      (rst),
        .head_nxt (head_nxt),
        .cnt_nxt  (cnt_nxt),
        .bad_nxt  (bad_nxt),
        .q_data   (q_data),
        .full     (full),
        .empty    (empty),
        .err      (err)
    );

endmodule

// File: rtl/wq_chk.sv
module wq_chk #(
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_data,
    input logic             pop,
    input logic [WIDTH-1:0] q_data,
    input logic             full,
    input logic             empty,
    input logic             err
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (empty && !full && !err && (q_data == '0)));

    // R5
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (q_data == '0));

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R3
    drop_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (full && in_valid && !pop) |=> (full && $stable(q_data)));

    // R6
    pop_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !in_valid) |=> empty);

    // R8
    empty_both_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && in_valid && pop) |=> (!empty && (q_data == $past(in_data))));

    // R8
    full_both_chk: assert property (@(posedge clk) disable iff (rst)
        (full && in_valid && pop) |=> (!full && !empty));

    // R11
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !err);

endmodule

bind word_queue wq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .pop      (pop),
    .q_data   (q_data),
    .full     (full),
    .empty    (empty),
    .err      (err)
);

// File: tb/word_queue_test.sv
`timescale 1ns/1ps
module word_queue_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        pop = 1'b0;
    logic [63:0] q_data;
    logic        full, empty, err;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] mq [$];

    always #5 clk = ~clk;

    word_queue uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .pop(pop), .q_data(q_data), .full(full), .empty(empty), .err(err)
    );

    task automatic ck(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare all outputs against the queue model
    task automatic compare(string req);
        ck(req, "q_data", q_data, (mq.size() > 0) ? mq[0] : 64'd0);
        ck(req, "full",   64'(full),  64'(mq.size() == 4));
        ck(req, "empty",  64'(empty), 64'(mq.size() == 0));
        ck("R11", "err",  64'(err),   64'd0);
    endtask

    // Apply one cycle of stimulus (called just after a falling edge)
    task automatic step(string req, logic v, logic [63:0] d, logic p);
        bit push_ok, pop_ok;
        in_valid = v; in_data = d; pop = p;
        push_ok = v && (mq.size() < 4);
        pop_ok  = p && (mq.size() > 0);
        @(posedge clk);
        if (pop_ok)  void'(mq.pop_front());
        if (push_ok) mq.push_back(d);
        @(negedge clk);
        in_valid = 1'b0; pop = 1'b0;
        compare(req);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        mq.delete();
        ck("R1", "empty", 64'(empty), 64'd1);
        ck("R1", "full",  64'(full),  64'd0);
        ck("R1", "err",   64'(err),   64'd0);
        ck("R5", "q_data", q_data, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_fill_order;
        step("R4", 1'b1, 64'hA5A5_0000_0000_0001, 1'b0);
        ck("R4", "head after first push", q_data, 64'hA5A5_0000_0000_0001);
        step("R2", 1'b1, 64'hA5A5_0000_0000_0002, 1'b0);
        step("R2", 1'b1, 64'hA5A5_0000_0000_0003, 1'b0);
        step("R9", 1'b1, 64'hA5A5_0000_0000_0004, 1'b0);
        ck("R9", "full at four", 64'(full), 64'd1);
        for (int i = 0; i < 4; i++) step("R2", 1'b0, '0, 1'b1);
        ck("R5", "empty after drain", 64'(empty), 64'd1);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 4; i++) step("R2", 1'b1, 64'hF00D_0000_0000_0010 + 64'(i), 1'b0);
        step("R3", 1'b1, 64'hDEAD_BEEF_DEAD_BEEF, 1'b0);
        ck("R3", "head kept", q_data, 64'hF00D_0000_0000_0010);
        step("R3", 1'b1, 64'hDEAD_BEEF_0000_0000, 1'b0);
        for (int i = 0; i < 4; i++) step("R3", 1'b0, '0, 1'b1);
    endtask

    task automatic t_underflow;
        step("R6", 1'b0, '0, 1'b1);
        step("R6", 1'b0, '0, 1'b1);
        ck("R6", "still empty", 64'(empty), 64'd1);
        step("R6", 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0);
        step("R6", 1'b0, '0, 1'b1);
        ck("R5", "zero when empty", q_data, 64'd0);
    endtask

    task automatic t_simul_mid;
        for (int fill = 1; fill <= 3; fill++) begin
            for (int i = 0; i < fill; i++) step("R7", 1'b1, 64'h7700_0000_0000_0000 + 64'(fill * 16 + i), 1'b0);
            step("R7", 1'b1, 64'h7777_0000_0000_0000 + 64'(fill), 1'b1);
            step("R7", 1'b1, 64'h7788_0000_0000_0000 + 64'(fill), 1'b1);
            for (int i = 0; i < fill; i++) step("R7", 1'b0, '0, 1'b1);
            ck("R7", "empty after same count drained", 64'(empty), 64'd1);
        end
    endtask

    task automatic t_simul_edges;
        step("R8", 1'b1, 64'h0E0E_0E0E_0E0E_0E0E, 1'b1);
        ck("R8", "push only on empty", q_data, 64'h0E0E_0E0E_0E0E_0E0E);
        for (int i = 0; i < 3; i++) step("R8", 1'b1, 64'h0F00_0000_0000_0000 + 64'(i), 1'b0);
        step("R8", 1'b1, 64'hBAD0_BAD0_BAD0_BAD0, 1'b1);
        ck("R8", "pop only on full", 64'(full), 64'd0);
        for (int i = 0; i < 3; i++) step("R8", 1'b0, '0, 1'b1);
        ck("R8", "new word dropped", 64'(empty), 64'd1);
    endtask

    task automatic t_mid_cycle;
        in_valid = 1'b1; in_data = 64'hCAFE_CAFE_CAFE_CAFE;
        #2;
        ck("R10", "empty held", 64'(empty), 64'd1);
        ck("R10", "data held", q_data, 64'd0);
        in_valid = 1'b0;
        #1;
        pop = 1'b1;
        #1;
        ck("R10", "data held on pop", q_data, 64'd0);
        pop = 1'b0;
        @(negedge clk);
        compare("R10");
        step("R10", 1'b1, 64'h5555_AAAA_5555_AAAA, 1'b0);
        pop = 1'b1;
        #2;
        ck("R10", "head held before edge", q_data, 64'h5555_AAAA_5555_AAAA);
        pop = 1'b0;
        @(negedge clk);
        compare("R10");
        step("R10", 1'b0, '0, 1'b1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_fill_order;
        t_overflow;
        t_underflow;
        t_simul_mid;
        t_simul_edges;
        t_mid_cycle;
        step("R1", 1'b1, 64'h1111_2222_3333_4444, 1'b0);
        t_reset;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule